// File: doc/BRIEF.md
# Host Command Mailbox Controller

The block sits between an external host processor and an on-chip processing engine. It holds a 64-byte shared memory and a small bank of interrupt registers, both reached over an 8-bit parallel bus with a 7-bit address. A select pin picks the host strobe convention:

- **Intel-style:** separate read and write strobes.
- **Motorola-style:** one data strobe plus a read/write line.

Inside the shared memory sit a command byte, four parameter bytes, an acknowledge counter, two report bytes, an error byte, and a status area that the engine keeps up to date.

The host writes the parameters, then writes a nonzero command byte. The block then offers the command to the engine on a valid/ready stream:

- `cmd_valid` stays high until the engine raises `cmd_ready`. No command is lost to back-pressure.
- On the handshake the command byte is cleared, so the host sees that the command was taken.
- When the engine finishes, it pulses `ack_valid` with zero to two report bytes. The block stores them and increments the acknowledge counter. The host waits for that counter to change before it issues another command.

Error codes from the engine land in the error byte and raise an error flag. Each interrupt source has a sticky flag and a mask, and `irq` is the OR of the enabled flags.

A hardware reset, or the initialisation command code, runs a startup sequence. The sequence wipes the shared memory, waits a set number of cycles, clears the command byte again and raises the acknowledge flag.

Top module: `hmbx_top`

## Requirements
- R1: Host reads of addresses 0x00–0x3F return the shared memory. 0x40 returns the flag register and 0x41 the mask register. Every other address reads 0x00 and ignores writes. `h_rdata` is 0x00 whenever no read is active.
- R2: A read is active when `h_cs_n` and `h_strb_n` are low and `h_wr_n` is high. With `bus_mode`=0, a write happens whenever `h_cs_n` and `h_wr_n` are low, regardless of `h_strb_n`. With `bus_mode`=1, a write also needs `h_strb_n` low. Each write assertion commits exactly once, at the first clock edge that sees it.
- R3: While the startup sequence is not running and byte 0x00 is nonzero and not the init code, `cmd_valid` is high. `cmd_code` equals byte 0x00 and `cmd_par` equals {0x04,0x03,0x02,0x01}, with byte 0x01 in bits [7:0]. `cmd_valid` holds while `cmd_ready` is low.
- R4: On an edge with `cmd_valid` and `cmd_ready` both high, byte 0x00 becomes 0x00 and `cmd_valid` drops in the next cycle.
- R5: An edge with `ack_valid` high does all of the following:
  - increments byte 0x05 modulo 256;
  - writes `ack_rep0` to 0x06 when `ack_nrep`≥1;
  - writes `ack_rep1` to 0x07 when `ack_nrep`≥2 (`ack_nrep`=0 leaves both bytes untouched);
  - sets flag bit 6.
- R6: An edge with `err_valid` high writes `err_code` to byte 0x08 and sets flag bit 0.
- R7: Flags are sticky. Writing 1 to a bit of 0x40 clears it, but a flag set in the same cycle wins. The mask at 0x41 resets to 0x40. `irq` is high exactly when some flag bit and its mask bit are both 1.
- R8: An edge with `eng_we` high writes `eng_wdata` to shared byte `eng_addr`, and host reads see the new value.
- R9: After reset release (two-stage synchroniser), the sequence zeroes all 64 bytes one per cycle, waits `INIT_WAIT` cycles and then sets flag bit 6. Flag bit 6 therefore appears no earlier than 64+`INIT_WAIT` cycles after release. While the sequence runs, `cmd_valid` is low and shared-memory writes from the host, engine, acknowledge and error inputs are dropped.
- R10: Byte 0x00 equal to `INIT_CODE` (default 0x01) is never offered on `cmd_valid`. It starts the same sequence, which also clears all flags, keeps the mask, and ends by setting flag bit 6.
- R11: When several writers target one shared byte in one cycle, the priority is: command clear, acknowledge and error writes first; then the engine port; then the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, synchronised inside |
| bus_mode | input | 1 | 0 = separate read/write strobes, 1 = data strobe plus read/write line |
| h_cs_n | input | 1 | Host chip select, active low |
| h_strb_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| h_wr_n | input | 1 | Write strobe (mode 0) or read/write line, low = write (mode 1) |
| h_addr | input | 7 | Host address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, 0 when no read is active |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_code | output | 8 | Command byte |
| cmd_par | output | 32 | Four parameter bytes |
| ack_valid | input | 1 | Engine posts an acknowledge |
| ack_nrep | input | 2 | Number of report bytes (0, 1, 2 or more) |
| ack_rep0 | input | 8 | First report byte |
| ack_rep1 | input | 8 | Second report byte |
| err_valid | input | 1 | Engine reports an error |
| err_code | input | 8 | Error code |
| eng_we | input | 1 | Engine status write |
| eng_addr | input | 6 | Engine write address in shared memory |
| eng_wdata | input | 8 | Engine write data |
| irq | output | 1 | Interrupt request to the host |

## Verification
Host reads are combinational, so the bench samples `h_rdata` 1 ns after the falling edge at which it sets the address. Every write (host, engine, acknowledge, error, command clear) shows up in the memory and flags one rising edge after the falling edge that drove it. The bench therefore checks results at the next falling edge.

The startup sequence completes 2 + 64 + `INIT_WAIT` + 1 edges after reset release. The bench counts falling edges until `irq` rises and accepts only a narrow window around that figure. The init command takes one edge fewer, because it needs no synchroniser.

Collisions and set-over-clear cases are driven within a single falling edge, so both contenders meet at the same rising edge.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;
  localparam logic [6:0] A_FLAGS = 7'h40;
  localparam logic [6:0] A_MASK  = 7'h41;
  localparam int OFS_CMD    = 0;
  localparam int OFS_ACKCNT = 5;
  localparam int OFS_REP0   = 6;
  localparam int OFS_REP1   = 7;
  localparam int OFS_ERR    = 8;
  localparam int IRQ_ERR_BIT = 0;
  localparam int IRQ_ACK_BIT = 6;
  localparam logic [7:0] MASK_RST = 8'h40;
  typedef enum logic [1:0] {SQ_RUN, SQ_CLEAR, SQ_WAIT, SQ_FIN} seq_state_e;
endpackage

// File: rtl/hmbx_busdec.sv
module hmbx_busdec (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic cs_n,
  input  logic strb_n,
  input  logic wr_n,
  output logic rd_act,
  output logic wr_pulse
);
  logic wr_lvl, wr_q;

  // both conventions read on strobe with write line high; writes differ
  assign rd_act = !cs_n && !strb_n && wr_n;
  assign wr_lvl = !cs_n && !wr_n && (mode ? !strb_n : 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_lvl;

  assign wr_pulse = wr_lvl && !wr_q;

  // R2: one commit per write assertion
  p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/hmbx_irqbank.sv
module hmbx_irqbank #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK_INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic [W-1:0] set_vec,
  input  logic         flag_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags,
  output logic [W-1:0] mask,
  output logic         irq
);
  for (genvar b = 0; b < W; b++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)            flags[b] <= 1'b0;
      else if (set_vec[b])   flags[b] <= 1'b1;
      else if (clr_all)      flags[b] <= 1'b0;
      else if (flag_we && wdata[b]) flags[b] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mask <= MASK_INIT;
    else if (mask_we) mask <= wdata;

  assign irq = |(flags & mask);

  // R7: a source set in a cycle is visible after that edge
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));
  // R7: written ones clear flags not being set
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> ((flags & $past(wdata & ~set_vec)) == '0));
endmodule

// File: rtl/hmbx_startseq.sv
module hmbx_startseq
  import hmbx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int INIT_WAIT = 200,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(INIT_WAIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          sweep_en,
  output logic [AW-1:0] sweep_idx,
  output logic          done
);
  seq_state_e      state;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= SQ_CLEAR;
      sweep_idx <= '0;
      cnt       <= '0;
    end else begin
      case (state)
        SQ_RUN: if (start) begin
          state     <= SQ_CLEAR;
          sweep_idx <= '0;
        end
        SQ_CLEAR: if (sweep_idx == AW'(DEPTH - 1)) begin
          state <= SQ_WAIT;
          cnt   <= '0;
        end else sweep_idx <= sweep_idx + 1'b1;
        SQ_WAIT: if (cnt == CW'(INIT_WAIT - 1)) state <= SQ_FIN;
                 else cnt <= cnt + 1'b1;
        default: state <= SQ_RUN;
      endcase
    end

  assign busy     = (state != SQ_RUN);
  assign sweep_en = (state == SQ_CLEAR);
  assign done     = (state == SQ_FIN);

  // R10: an init request begins the wipe at entry 0
  p_start_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (sweep_en && sweep_idx == '0));
  // R9: completion only follows the wait phase
  p_done_after_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state == SQ_WAIT));
endmodule

// File: rtl/hmbx_top.sv
module hmbx_top
  import hmbx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int INIT_WAIT = 200,
  parameter logic [7:0] INIT_CODE = 8'h01,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          bus_mode,
  input  logic          h_cs_n,
  input  logic          h_strb_n,
  input  logic          h_wr_n,
  input  logic [6:0]    h_addr,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [7:0]    cmd_code,
  output logic [31:0]   cmd_par,
  input  logic          ack_valid,
  input  logic [1:0]    ack_nrep,
  input  logic [7:0]    ack_rep0,
  input  logic [7:0]    ack_rep1,
  input  logic          err_valid,
  input  logic [7:0]    err_code,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [7:0]    eng_wdata,
  output logic          irq
);
  logic [1:0] rst_sync;
  logic       rst_n;
  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  assign rst_n = rst_sync[1];

  logic rd_act, wr_pulse;
  hmbx_busdec u_dec (
    .clk(clk), .rst_n(rst_n), .mode(bus_mode), .cs_n(h_cs_n),
    .strb_n(h_strb_n), .wr_n(h_wr_n), .rd_act(rd_act), .wr_pulse(wr_pulse));

  logic          busy, sweep_en, seq_done, start;
  logic [AW-1:0] sweep_idx;
  logic [7:0]    mem [DEPTH];

  assign start = !busy && (mem[OFS_CMD] == INIT_CODE);

  hmbx_startseq #(.DEPTH(DEPTH), .INIT_WAIT(INIT_WAIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .sweep_en(sweep_en), .sweep_idx(sweep_idx), .done(seq_done));

  logic [7:0] set_vec, flags, mask;
  logic       ram_hit, host_we, accept;

  assign ram_hit = (h_addr < 7'(DEPTH));
  assign host_we = wr_pulse && ram_hit && !busy;

  always_comb begin
    set_vec = '0;
    set_vec[IRQ_ACK_BIT] = (ack_valid && !busy) || seq_done;
    set_vec[IRQ_ERR_BIT] = err_valid && !busy;
  end

  hmbx_irqbank #(.W(8), .MASK_INIT(MASK_RST)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr_all(start), .set_vec(set_vec),
    .flag_we(wr_pulse && h_addr == A_FLAGS),
    .mask_we(wr_pulse && h_addr == A_MASK),
    .wdata(h_wdata), .flags(flags), .mask(mask), .irq(irq));

  // command stream
  assign cmd_code  = mem[OFS_CMD];
  assign cmd_par   = {mem[4], mem[3], mem[2], mem[1]};
  assign cmd_valid = !busy && (mem[OFS_CMD] != 8'h00) && (mem[OFS_CMD] != INIT_CODE);
  assign accept    = cmd_valid && cmd_ready;

  // block-internal writes, highest priority after the wipe
  logic [DEPTH-1:0] int_we;
  logic [7:0]       int_wd [DEPTH];
  always_comb begin
    int_we = '0;
    for (int i = 0; i < DEPTH; i++) int_wd[i] = 8'h00;
    if (accept) int_we[OFS_CMD] = 1'b1;
    if (ack_valid) begin
      int_we[OFS_ACKCNT] = 1'b1;
      int_wd[OFS_ACKCNT] = mem[OFS_ACKCNT] + 8'd1;
      if (ack_nrep != 2'd0) begin
        int_we[OFS_REP0] = 1'b1;
        int_wd[OFS_REP0] = ack_rep0;
      end
      if (ack_nrep[1]) begin
        int_we[OFS_REP1] = 1'b1;
        int_wd[OFS_REP1] = ack_rep1;
      end
    end
    if (err_valid) begin
      int_we[OFS_ERR] = 1'b1;
      int_wd[OFS_ERR] = err_code;
    end
  end

  always_ff @(posedge clk)
    for (int i = 0; i < DEPTH; i++) begin
      if (sweep_en && sweep_idx == AW'(i))              mem[i] <= 8'h00;
      else if (seq_done && i == OFS_CMD)                mem[i] <= 8'h00;
      else if (!busy) begin
        if (int_we[i])                                  mem[i] <= int_wd[i];
        else if (eng_we && eng_addr == AW'(i))          mem[i] <= eng_wdata;
        else if (host_we && h_addr[AW-1:0] == AW'(i))   mem[i] <= h_wdata;
      end
    end

  always_comb begin
    h_rdata = 8'h00;
    if (rd_act) begin
      if (ram_hit)                 h_rdata = mem[h_addr[AW-1:0]];
      else if (h_addr == A_FLAGS)  h_rdata = flags;
      else if (h_addr == A_MASK)   h_rdata = mask;
    end
  end

  // R4: a taken command is withdrawn
  p_accept_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_valid);
  // R5: each acknowledge advances the counter by one
  p_ack_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !busy) |=> (mem[OFS_ACKCNT] == $past(mem[OFS_ACKCNT]) + 8'd1));
  // R6, R11: error code lands even against an engine write
  p_err_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !busy) |=> (mem[OFS_ERR] == $past(err_code)));
endmodule

// File: tb/test_hmbx_top.sv
module test_hmbx_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int WAITC = 200;

  logic clk = 1'b0, arst_n = 1'b0, bus_mode = 1'b0;
  logic h_cs_n = 1'b1, h_strb_n = 1'b1, h_wr_n = 1'b1;
  logic [6:0] h_addr = '0;
  logic [7:0] h_wdata = '0, h_rdata;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [7:0] cmd_code;
  logic [31:0] cmd_par;
  logic ack_valid = 1'b0;
  logic [1:0] ack_nrep = '0;
  logic [7:0] ack_rep0 = '0, ack_rep1 = '0;
  logic err_valid = 1'b0;
  logic [7:0] err_code = '0;
  logic eng_we = 1'b0;
  logic [5:0] eng_addr = '0;
  logic [7:0] eng_wdata = '0;
  logic irq;

  hmbx_top #(.DEPTH(DEPTH), .INIT_WAIT(WAITC), .INIT_CODE(8'h01)) i_hmbx_top (
    .clk(clk), .arst_n(arst_n), .bus_mode(bus_mode), .h_cs_n(h_cs_n),
    .h_strb_n(h_strb_n), .h_wr_n(h_wr_n), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_par(cmd_par), .ack_valid(ack_valid),
    .ack_nrep(ack_nrep), .ack_rep0(ack_rep0), .ack_rep1(ack_rep1),
    .err_valid(err_valid), .err_code(err_code), .eng_we(eng_we),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] model [DEPTH];

  function automatic logic [31:0] exp_par(input logic [7:0] p0, p1, p2, p3);
    return {p3, p2, p1, p0};
  endfunction
  function automatic logic exp_irq(input logic [7:0] f, m);
    return |(f & m);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    h_addr = a; h_wdata = d; h_cs_n = 1'b0; h_wr_n = 1'b0; h_strb_n = bus_mode ? 1'b0 : 1'b1;
    @(negedge clk);
    h_cs_n = 1'b1; h_wr_n = 1'b1; h_strb_n = 1'b1;
  endtask

  task automatic host_rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    h_addr = a; h_cs_n = 1'b0; h_strb_n = 1'b0; h_wr_n = 1'b1;
    #1 d = h_rdata;
    h_cs_n = 1'b1; h_strb_n = 1'b1;
  endtask

  task automatic eng_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    eng_we = 1'b1; eng_addr = a; eng_wdata = d;
    @(negedge clk);
    eng_we = 1'b0;
  endtask

  task automatic post_ack(input logic [1:0] n, input logic [7:0] r0, input logic [7:0] r1);
    @(negedge clk);
    ack_valid = 1'b1; ack_nrep = n; ack_rep0 = r0; ack_rep1 = r1;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic wait_irq(input int lim, output int c);
    c = 0;
    while (!irq && c < lim) begin
      @(negedge clk);
      c++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL WDOG actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int c;
    int bad;
    void'($urandom(32'd4242));

    // reset state
    repeat (3) @(negedge clk);
    chk("R9 irq low in reset", irq, 0);
    chk("R9 cmd_valid low in reset", cmd_valid, 0);
    arst_n = 1'b1;
    wait_irq(64 + WAITC + 20, c);
    n_chk++;
    if (c < 64 + WAITC || c > 70 + WAITC) begin
      n_bad++;
      $display("FAIL R9 startup cycles actual=%0d expected=%0d", c, 67 + WAITC);
    end
    host_rd(7'h40, d); chk("R9 flags after startup", d, 8'h40);
    host_rd(7'h41, d); chk("R7 mask reset value", d, 8'h40);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      host_rd(7'(i), d);
      if (d !== 8'h00) bad++;
    end
    chk("R9 memory zero after startup", bad, 0);

    // R7 write-one-to-clear
    host_wr(7'h40, 8'h40);
    #1 chk("R7 irq cleared by W1C", irq, 0);

    // R1 map
    host_wr(7'h45, 8'hAA);
    host_rd(7'h45, d); chk("R1 unmapped reads zero", d, 8'h00);
    host_rd(7'h7F, d); chk("R1 top address reads zero", d, 8'h00);
    host_wr(7'h3F, 8'h6E);
    host_rd(7'h3F, d); chk("R1 last RAM byte", d, 8'h6E);
    @(negedge clk); h_addr = 7'h3F; #1 chk("R1 no read strobe gives zero", h_rdata, 8'h00);

    // R2 strobe conventions
    bus_mode = 1'b1;
    @(negedge clk); h_addr = 7'h10; h_wdata = 8'h5C; h_cs_n = 1'b0; h_wr_n = 1'b0; h_strb_n = 1'b1;
    @(negedge clk); h_cs_n = 1'b1; h_wr_n = 1'b1;
    host_rd(7'h10, d); chk("R2 mode1 write needs strobe", d, 8'h00);
    host_wr(7'h10, 8'h5C);
    host_rd(7'h10, d); chk("R2 mode1 strobed write", d, 8'h5C);
    bus_mode = 1'b0;
    @(negedge clk); h_addr = 7'h11; h_wdata = 8'h3D; h_cs_n = 1'b0; h_wr_n = 1'b0; h_strb_n = 1'b1;
    @(negedge clk); h_cs_n = 1'b1; h_wr_n = 1'b1;
    host_rd(7'h11, d); chk("R2 mode0 write strobe alone", d, 8'h3D);

    // R3 / R4 command stream
    host_wr(7'h01, 8'h11); host_wr(7'h02, 8'h22);
    host_wr(7'h03, 8'h33); host_wr(7'h04, 8'h44);
    chk("R3 no command before byte 0", cmd_valid, 0);
    host_wr(7'h00, 8'h5A);
    chk("R3 cmd_valid raised", cmd_valid, 1);
    chk("R3 cmd_code", cmd_code, 8'h5A);
    chk("R3 cmd_par packing", cmd_par, exp_par(8'h11, 8'h22, 8'h33, 8'h44));
    repeat (2) @(negedge clk);
    chk("R3 valid held under back-pressure", cmd_valid, 1);
    cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
    chk("R4 valid dropped after accept", cmd_valid, 0);
    host_rd(7'h00, d); chk("R4 command byte cleared", d, 8'h00);

    // R5 acknowledges
    post_ack(2'd2, 8'hA1, 8'hB2);
    host_rd(7'h05, d); chk("R5 counter after first ack", d, 8'h01);
    host_rd(7'h06, d); chk("R5 report 0", d, 8'hA1);
    host_rd(7'h07, d); chk("R5 report 1", d, 8'hB2);
    chk("R5 ack irq", irq, exp_irq(8'h40, 8'h40));
    post_ack(2'd1, 8'hC3, 8'hD4);
    host_rd(7'h06, d); chk("R5 single report byte", d, 8'hC3);
    host_rd(7'h07, d); chk("R5 second byte untouched", d, 8'hB2);
    post_ack(2'd0, 8'hEE, 8'hEE);
    host_rd(7'h05, d); chk("R5 counter after three acks", d, 8'h03);
    host_rd(7'h06, d); chk("R5 zero reports untouched", d, 8'hC3);

    // R7 set beats clear in one cycle
    @(negedge clk);
    ack_valid = 1'b1; ack_nrep = 2'd0;
    h_addr = 7'h40; h_wdata = 8'h40; h_cs_n = 1'b0; h_wr_n = 1'b0;
    @(negedge clk);
    ack_valid = 1'b0; h_cs_n = 1'b1; h_wr_n = 1'b1;
    host_rd(7'h40, d); chk("R7 set wins over clear", d, 8'h40);

    // R6 error and masking
    host_wr(7'h40, 8'hFF);
    @(negedge clk); err_valid = 1'b1; err_code = 8'h77;
    @(negedge clk); err_valid = 1'b0;
    host_rd(7'h08, d); chk("R6 error code stored", d, 8'h77);
    host_rd(7'h40, d); chk("R6 error flag", d, 8'h01);
    chk("R7 masked error keeps irq low", irq, exp_irq(8'h01, 8'h40));
    host_wr(7'h41, 8'h41);
    chk("R7 enabled error raises irq", irq, exp_irq(8'h01, 8'h41));

    // R8 / R11 collisions
    eng_wr(6'h0C, 8'h9D);
    host_rd(7'h0C, d); chk("R8 engine status write", d, 8'h9D);
    @(negedge clk);
    eng_we = 1'b1; eng_addr = 6'h0A; eng_wdata = 8'hE1;
    h_addr = 7'h0A; h_wdata = 8'h1E; h_cs_n = 1'b0; h_wr_n = 1'b0;
    @(negedge clk);
    eng_we = 1'b0; h_cs_n = 1'b1; h_wr_n = 1'b1;
    host_rd(7'h0A, d); chk("R11 engine beats host", d, 8'hE1);
    @(negedge clk);
    eng_we = 1'b1; eng_addr = 6'h08; eng_wdata = 8'h33; err_valid = 1'b1; err_code = 8'h55;
    @(negedge clk);
    eng_we = 1'b0; err_valid = 1'b0;
    host_rd(7'h08, d); chk("R11 error beats engine port", d, 8'h55);

    // R10 init command
    host_wr(7'h00, 8'h01);
    chk("R10 init code not offered", cmd_valid, 0);
    repeat (70) @(negedge clk);
    chk("R10 irq low while busy", irq, 0);
    host_wr(7'h20, 8'h99);
    eng_wr(6'h21, 8'h98);
    wait_irq(64 + WAITC + 10, c);
    chk("R10 completion irq", irq, 1);
    host_rd(7'h40, d); chk("R10 flags cleared then ack set", d, 8'h40);
    host_rd(7'h41, d); chk("R10 mask kept", d, 8'h41);
    host_rd(7'h01, d); chk("R10 parameters wiped", d, 8'h00);
    host_rd(7'h05, d); chk("R10 counter wiped", d, 8'h00);
    host_rd(7'h20, d); chk("R9 host write dropped while busy", d, 8'h00);
    host_rd(7'h21, d); chk("R9 engine write dropped while busy", d, 8'h00);

    // random mix against a model
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [5:0] a;
      logic [7:0] v, v2;
      op = $urandom_range(0, 3);
      a  = 6'($urandom_range(9, 63));
      v  = 8'($urandom);
      v2 = 8'($urandom);
      case (op)
        0: begin host_wr({1'b0, a}, v); model[a] = v; end
        1: begin eng_wr(a, v); model[a] = v; end
        2: begin host_rd({1'b0, a}, d); chk("R8 random readback", d, model[a]); end
        default: begin
          logic [1:0] n;
          n = 2'($urandom_range(0, 3));
          post_ack(n, v, v2);
          model[5] = model[5] + 8'd1;
          if (n != 2'd0) model[6] = v;
          if (n[1]) model[7] = v2;
        end
      endcase
    end
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      host_rd(7'(i), d);
      if (d !== model[i]) bad++;
    end
    chk("R5 R8 final memory sweep", bad, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule